// File: doc/BRIEF.md
# Timer-Paced Dual-Line Serial ADC Reader

This block is the host end of a serial link to a converter that samples two channels at once and returns them on two separate data lines. A free-running serial clock is made from the master clock by a programmable divider. A reloadable pacing timer raises a request at a fixed interval. Each request starts one frame. The reader first waits until it has seen the serial clock high, then low, then high again. It then pulls the shared active-low select line down and keeps it down for the whole word. Both data lines are shifted in together. At the end of the frame the two results are presented with a one-cycle strobe.

Words are 16 serial clocks long by default, or 14 when the short-word option is set. A separate request sends an 8-clock frame that tells the converter to power down. A pacing request that arrives while a frame is still being set up or shifted is discarded and noted in a sticky flag.

Top module: `dual_adc_reader`

## Requirements
- R1: `sclk` runs at all times outside reset. Each level is held for exactly `cfg_div`+1 master clocks, so one full period is 2×(`cfg_div`+1) master clocks.
- R2: While `cfg_enable` is high, the pacing timer requests a frame once every `cfg_load`+1 master clocks. When that interval is a whole number of `sclk` periods, successive falls of `cs_n` are exactly `cfg_load`+1 cycles apart. When it is not a whole number, each spacing is still a whole number of `sclk` periods.
- R3: After a request, `cs_n` falls only once `sclk` has been observed high, then low, then high. It falls on the clock edge after the cycle in which that final high level is seen.
- R4: `cs_n` stays low for a whole word and rises on the edge that samples the last bit. A data frame spans 16 falling `sclk` edges when `cfg_short_word`=0, and 14 when it is 1. The option is captured when the request is accepted.
- R5: Both `sdata_a` and `sdata_b` are sampled on the same falling `sclk` edges, most significant bit first. Each result is right-justified in its 16-bit output, with the bits above the word length cleared.
- R6: `res_valid` is high for exactly one cycle, the first cycle in which `cs_n` is high again after a data frame. `res_a` and `res_b` change only in that cycle and are held otherwise.
- R7: Between two frames, `cs_n` stays high for at least one full `sclk` period.
- R8: A pacing request that arrives while a frame is being set up or shifted is dropped and sets `overrun`. `overrun` stays set until reset.
- R9: A pulse on `pd_req` produces one frame of exactly 8 falling `sclk` edges with the same alignment. That frame raises no `res_valid` and leaves `res_a` and `res_b` unchanged. If the reader is busy, the request waits. If it meets a pacing request in an idle cycle, it wins and the pacing request counts as an overrun.
- R10: After reset, `cs_n`=1, `res_valid`=0, `overrun`=0, and `res_a` = `res_b` = 0.
- R11: With `cfg_enable` low and no `pd_req`, no frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Runs the pacing timer |
| cfg_short_word | input | 1 | Selects the 14-clock word instead of 16 |
| cfg_div | input | DIV_W | Serial clock divider; period is 2×(cfg_div+1) |
| cfg_load | input | LOAD_W | Pacing interval minus one, in master clocks |
| pd_req | input | 1 | One-cycle request for a power-down burst |
| sdata_a | input | 1 | Serial data from channel A |
| sdata_b | input | 1 | Serial data from channel B |
| sclk | output | 1 | Free-running serial clock |
| cs_n | output | 1 | Active-low frame / chip select |
| res_a | output | WORD_W | Right-justified channel A result |
| res_b | output | WORD_W | Right-justified channel B result |
| res_valid | output | 1 | One-cycle strobe for a new result pair |
| overrun | output | 1 | Sticky flag for dropped pacing requests |

## Verification
The bound checker watches several properties on every cycle:
- the half-period length of `sclk`;
- that every fall of `cs_n` follows a cycle with `sclk` high;
- the minimum high time of `cs_n` between frames;
- that the strobe is a single cycle and coincides with the rise of `cs_n`;
- that the results hold between strobes;
- that `overrun` is sticky.

Some behaviour is visible only from the bench's scenarios, which sweep the divider and both word lengths. These include:
- the exact number of falling edges per frame;
- the bit order and right-justification of data;
- equal frame spacing when the interval is a whole number of serial periods, and its quantised spacing when it is not;
- the dropping of early requests;
- the power-down burst.

// File: rtl/dual_adc_rd_pkg.sv
package dual_adc_rd_pkg;

    // Frame sequencer states; the three SEEK states form the high-low-high alignment
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SEEK_HI  = 3'd1,
        ST_SEEK_LO  = 3'd2,
        ST_SEEK_HI2 = 3'd3,
        ST_SHIFT    = 3'd4
    } rd_state_e;

endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             fall_evt
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } gen_t;

    gen_t gen_d, gen_q;
    logic wrap;

    assign wrap = (gen_q.cnt >= div);

    always_comb begin
        gen_d = gen_q;
        if (wrap) begin
            gen_d.cnt = '0;
            gen_d.lvl = ~gen_q.lvl;
        end else begin
            gen_d.cnt = gen_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sclk     = gen_q.lvl;
    // The edge on which sclk goes from high to low
    assign fall_evt = wrap && gen_q.lvl;

endmodule

// File: rtl/adcrd_pace_timer.sv
module adcrd_pace_timer #(
    parameter int LOAD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LOAD_W-1:0] load,
    output logic              tick
);

    typedef struct packed {
        logic [LOAD_W-1:0] cnt;
        logic              tick;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.tick = 1'b0;
        if (!en) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt >= load) begin
            tmr_d.cnt  = '0;
            tmr_d.tick = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + LOAD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick = tmr_q.tick;

endmodule

// File: rtl/adcrd_lane_shift.sv
module adcrd_lane_shift #(
    parameter int LANES  = 2,
    parameter int WORD_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          shift_en,
    input  logic [LANES-1:0]              din,
    output logic [LANES-1:0][WORD_W-1:0]  word_next
);

    // Only WORD_W-1 bits are held; the final bit is taken straight from the line
    localparam int HOLD_W = WORD_W - 1;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [HOLD_W-1:0] hold_d, hold_q;

            always_comb begin
                hold_d = hold_q;
                if (clear)         hold_d = '0;
                else if (shift_en) hold_d = {hold_q[HOLD_W-2:0], din[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hold_q <= '0;
                else        hold_q <= hold_d;
            end

            assign word_next[g] = {hold_q, din[g]};
        end
    endgenerate

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import dual_adc_rd_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int LOAD_W    = 16,
    parameter int WORD_W    = 16,
    parameter int SHORT_LEN = 14,
    parameter int PD_LEN    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_short_word,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [LOAD_W-1:0] cfg_load,
    input  logic              pd_req,
    input  logic              sdata_a,
    input  logic              sdata_b,
    output logic              sclk,
    output logic              cs_n,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_b,
    output logic              res_valid,
    output logic              overrun
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int LANES = 2;

    typedef struct packed {
        rd_state_e         st;
        logic [CNT_W-1:0]  bits;
        logic [CNT_W-1:0]  len;
        logic              pd_frame;
        logic              pd_pend;
        logic              cs_n;
        logic              valid;
        logic              ovr;
        logic [WORD_W-1:0] ra;
        logic [WORD_W-1:0] rb;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                             sclk_lvl;
    logic                             fall_evt;
    logic                             tick;
    logic                             sh_clear;
    logic                             sh_en;
    logic [LANES-1:0][WORD_W-1:0]     word_next;
    logic [WORD_W-1:0]                len_mask;
    logic                             last_bit;

    adcrd_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .div      (cfg_div),
        .sclk     (sclk_lvl),
        .fall_evt (fall_evt)
    );

    adcrd_pace_timer #(.LOAD_W(LOAD_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_enable),
        .load  (cfg_load),
        .tick  (tick)
    );

    adcrd_lane_shift #(.LANES(LANES), .WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .shift_en  (sh_en),
        .din       ({sdata_b, sdata_a}),
        .word_next (word_next)
    );

    assign len_mask = ~({WORD_W{1'b1}} << ctl_q.len);
    assign last_bit = (ctl_q.bits == ctl_q.len - CNT_W'(1));
    assign sh_clear = (ctl_q.st == ST_SEEK_HI2) && sclk_lvl;
    assign sh_en    = (ctl_q.st == ST_SHIFT) && fall_evt;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        if (pd_req) ctl_d.pd_pend = 1'b1;

        // Any pacing request outside idle is lost
        if (tick && (ctl_q.st != ST_IDLE)) ctl_d.ovr = 1'b1;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ctl_q.pd_pend || pd_req) begin
                    ctl_d.st       = ST_SEEK_HI;
                    ctl_d.pd_frame = 1'b1;
                    ctl_d.pd_pend  = 1'b0;
                    ctl_d.len      = CNT_W'(PD_LEN);
                    if (tick) ctl_d.ovr = 1'b1;
                end else if (tick) begin
                    ctl_d.st       = ST_SEEK_HI;
                    ctl_d.pd_frame = 1'b0;
                    ctl_d.len      = cfg_short_word ? CNT_W'(SHORT_LEN) : CNT_W'(WORD_W);
                end
            end
            ST_SEEK_HI: begin
                if (sclk_lvl) ctl_d.st = ST_SEEK_LO;
            end
            ST_SEEK_LO: begin
                if (!sclk_lvl) ctl_d.st = ST_SEEK_HI2;
            end
            ST_SEEK_HI2: begin
                if (sclk_lvl) begin
                    ctl_d.st   = ST_SHIFT;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.bits = '0;
                end
            end
            ST_SHIFT: begin
                if (fall_evt) begin
                    if (last_bit) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.cs_n = 1'b1;
                        if (!ctl_q.pd_frame) begin
                            ctl_d.valid = 1'b1;
                            ctl_d.ra    = word_next[0] & len_mask;
                            ctl_d.rb    = word_next[1] & len_mask;
                        end
                    end else begin
                        ctl_d.bits = ctl_q.bits + CNT_W'(1);
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.cs_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sclk      = sclk_lvl;
    assign cs_n      = ctl_q.cs_n;
    assign res_a     = ctl_q.ra;
    assign res_b     = ctl_q.rb;
    assign res_valid = ctl_q.valid;
    assign overrun   = ctl_q.ovr;

endmodule

// File: rtl/dual_adc_reader_chk.sv
module dual_adc_reader_chk #(
    parameter int DIV_W  = 8,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIV_W-1:0]  cfg_div,
    input logic              sclk,
    input logic              cs_n,
    input logic [WORD_W-1:0] res_a,
    input logic [WORD_W-1:0] res_b,
    input logic              res_valid,
    input logic              overrun
);

    logic             prv_sclk_q;
    logic [DIV_W:0]   run_q;
    logic             seen_q;
    logic [DIV_W-1:0] prv_div_q;
    logic [31:0]      hi_cnt_q;
    logic [31:0]      min_gap;

    assign min_gap = (32'(cfg_div) + 32'd1) * 32'd2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv_sclk_q <= 1'b0;
            run_q      <= '0;
            seen_q     <= 1'b0;
            prv_div_q  <= '0;
            hi_cnt_q   <= '0;
        end else begin
            prv_sclk_q <= sclk;
            prv_div_q  <= cfg_div;
            if (sclk != prv_sclk_q) begin
                run_q  <= '0;
                seen_q <= (cfg_div == prv_div_q);
            end else begin
                run_q <= run_q + 1'b1;
            end
            if (cfg_div != prv_div_q) seen_q <= 1'b0;
            if (!cs_n) hi_cnt_q <= '0;
            else if (hi_cnt_q != 32'hFFFF_FFFF) hi_cnt_q <= hi_cnt_q + 32'd1;
        end
    end

    AST_SCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ((sclk != prv_sclk_q) && seen_q && (cfg_div == prv_div_q)) |-> (run_q == (DIV_W+1)'(cfg_div))); // R1

    AST_FRAME_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(sclk)); // R3

    AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(hi_cnt_q) + 32'd1 >= min_gap)); // R7

    AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (cs_n && !$past(cs_n))); // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_a) && $stable(res_b))); // R6

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8

endmodule

bind dual_adc_reader dual_adc_reader_chk #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_div   (cfg_div),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .res_a     (res_a),
    .res_b     (res_b),
    .res_valid (res_valid),
    .overrun   (overrun)
);

// File: tb/tb_dual_adc_reader.sv
`timescale 1ns/1ps
module tb_dual_adc_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_short_word = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic [15:0] cfg_load = 16'd0;
    logic        pd_req = 1'b0;
    logic        sdata_a = 1'b0;
    logic        sdata_b = 1'b0;
    logic        sclk, cs_n, res_valid, overrun;
    logic [15:0] res_a, res_b;

    always #4 clk = ~clk;

    dual_adc_reader dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_short_word(cfg_short_word),
        .cfg_div(cfg_div), .cfg_load(cfg_load), .pd_req(pd_req),
        .sdata_a(sdata_a), .sdata_b(sdata_b), .sclk(sclk), .cs_n(cs_n),
        .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .overrun(overrun)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // Monitor / converter model state
    int exp_per, exp_falls, exp_intv, mode, per_skip, cur_div;
    bit pd_mode;
    int bad_per, bad_intv, bad_sync, bad_falls, bad_data, bad_gap;
    int nvalid, frames_done, starts, frame_no;
    int last_srise, last_start, last_cs_rise, idx;
    logic prev_cs, prev_sclk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] wgen(input int f, input int lane);
        logic [15:0] v;
        v = 16'(f * 16'h9E37 + 16'h1B4D);
        return lane == 0 ? (v ^ 16'hC3C3) : {v[7:0], v[15:8]} ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] lmask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        bad_per = 0; bad_intv = 0; bad_sync = 0; bad_falls = 0; bad_data = 0; bad_gap = 0;
        nvalid = 0; frames_done = 0; starts = 0;
        last_srise = -1; last_start = -1; per_skip = 2;
    endtask

    // Converter model and monitor, evaluated away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sclk = 1'b0; idx = 0;
            sdata_a = 1'b0; sdata_b = 1'b0; last_cs_rise = -1;
        end else begin
            if (sclk && !prev_sclk) begin
                if (per_skip > 0) per_skip--;
                else if (cyc - last_srise != exp_per) bad_per++;
                last_srise = cyc;
            end
            if (prev_cs && !cs_n) begin
                frame_no++;
                starts++;
                if (!prev_sclk) bad_sync++;
                if (last_cs_rise >= 0 && (cyc - last_cs_rise) < 2 * (cur_div + 1)) bad_gap++;
                if (last_start >= 0) begin
                    if (mode == 1 && (cyc - last_start) != exp_intv) bad_intv++;
                    if (mode == 2 && (((cyc - last_start) % exp_per) != 0 ||
                        (cyc - last_start) < exp_intv - exp_per ||
                        (cyc - last_start) > exp_intv + exp_per)) bad_intv++;
                end
                last_start = cyc;
                idx = 0;
            end else if (!prev_cs && !cs_n && prev_sclk && !sclk) begin
                idx++;
            end
            if (!prev_cs && cs_n) begin
                if (idx + ((prev_sclk && !sclk) ? 1 : 0) != exp_falls) bad_falls++;
                frames_done++;
                last_cs_rise = cyc;
            end
            if (res_valid) begin
                nvalid++;
                if (pd_mode) bad_data++;
                else if (res_a != (wgen(frame_no, 0) & lmask(exp_falls)) ||
                         res_b != (wgen(frame_no, 1) & lmask(exp_falls))) begin
                    bad_data++;
                    $display("data mismatch a=%h b=%h", res_a, res_b);
                end
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
            if (!cs_n && idx < exp_falls) begin
                sdata_a = wgen(frame_no, 0)[exp_falls - 1 - idx];
                sdata_b = wgen(frame_no, 1)[exp_falls - 1 - idx];
            end else begin
                sdata_a = 1'b0;
                sdata_b = 1'b0;
            end
        end
    end

    task automatic run_cfg(input int div, input bit short_w, input int load, input int nfr,
                           input int md, input bit exp_ovr);
        @(posedge clk); #1;
        cfg_enable = 1'b0;
        cfg_div = 8'(div);
        cfg_short_word = short_w;
        cfg_load = 16'(load);
        exp_per = 2 * (div + 1);
        exp_falls = short_w ? 14 : 16;
        exp_intv = load + 1;
        mode = md;
        cur_div = div;
        pd_mode = 1'b0;
        clear_stats();
        repeat (4 * exp_per + 4) @(posedge clk);
        #1 cfg_enable = 1'b1;
        for (int i = 0; i < 40000 && frames_done < nfr; i++) @(posedge clk);
        #1 cfg_enable = 1'b0;
        repeat (60 * (div + 1)) @(posedge clk);
        #1;
        check(bad_per == 0, "R1 sclk period", bad_per, 0);
        if (md != 0) check(bad_intv == 0, "R2 frame spacing", bad_intv, 0);
        check(bad_sync == 0, "R3 alignment", bad_sync, 0);
        check(bad_falls == 0 && frames_done >= nfr, "R4 edges per frame", bad_falls, 0);
        check(bad_data == 0, "R5 data", bad_data, 0);
        check(nvalid == frames_done, "R6 strobe per frame", nvalid, frames_done);
        check(bad_gap == 0, "R7 frame gap", bad_gap, 0);
        check(overrun == exp_ovr, "R8 overrun flag", int'(overrun), int'(exp_ovr));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [15:0] snap_a, snap_b;
        int st0;
        frame_no = 0; cur_div = 0; exp_per = 2; exp_falls = 16; mode = 0; pd_mode = 1'b0;
        clear_stats();
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(cs_n == 1'b1, "R10 cs_n", int'(cs_n), 1);
        check(res_valid == 1'b0, "R10 res_valid", int'(res_valid), 0);
        check(overrun == 1'b0, "R10 overrun", int'(overrun), 0);
        check(res_a == 16'd0 && res_b == 16'd0, "R10 results", int'(res_a | res_b), 0);

        // Sweep divider and word length with whole-period intervals (R1-style checks per config)
        for (int d = 0; d < 4; d++) begin
            for (int s = 0; s < 2; s++) begin
                run_cfg(d, s[0], 48 * (d + 1) - 1, 6, 1, 1'b0);
            end
        end

        // Interval of 100.5 serial periods: spacing quantised to the sclk period (R2)
        run_cfg(3, 1'b0, 803, 4, 2, 1'b0);

        // Requests faster than frames: overrun (R8)
        run_cfg(0, 1'b0, 10, 5, 0, 1'b1);
        repeat (200) @(posedge clk);
        #1 check(overrun == 1'b1, "R8 sticky", int'(overrun), 1);

        // R11 no frames while disabled
        st0 = starts;
        repeat (500) @(posedge clk);
        #1 check(starts == st0, "R11 idle", starts - st0, 0);

        // R9 power-down burst
        @(posedge clk); #1;
        cfg_div = 8'd1; cur_div = 1; exp_per = 4; exp_falls = 8; pd_mode = 1'b1; mode = 0;
        clear_stats();
        repeat (20) @(posedge clk);
        #1;
        snap_a = res_a; snap_b = res_b;
        pd_req = 1'b1;
        @(posedge clk); #1 pd_req = 1'b0;
        for (int i = 0; i < 2000 && frames_done < 1; i++) @(posedge clk);
        repeat (40) @(posedge clk);
        #1;
        check(frames_done == 1, "R9 one burst frame", frames_done, 1);
        check(bad_falls == 0, "R9 eight edges", bad_falls, 0);
        check(nvalid == 0, "R9 no strobe", nvalid, 0);
        check(res_a == snap_a && res_b == snap_b, "R9 results kept", int'(res_a), int'(snap_a));
        check(bad_sync == 0, "R3 burst alignment", bad_sync, 0);

        // Reset clears the sticky flag (R10)
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(overrun == 1'b0, "R10 overrun after reset", int'(overrun), 0);
        check(cs_n == 1'b1 && res_a == 16'd0, "R10 outputs after reset", int'(res_a), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule